// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block sits between register read and the memory stage of a load-store datapath. It turns one addressing request into either a ready operand or a final memory address. A request carries a mode code, a base register value, an index register value, one sign-extended constant field (used as displacement, immediate or absolute address), and a 2-bit access-size code. Modes that update their base register also return a write-back value for the register file.

For the memory-indirect mode the unit reads a pointer word through a valid/ready memory port, and returns that word as the final address. The caller then uses that address for the second access. Requests are accepted only while the unit is idle. Each result is held on a valid/ready result port until the consumer takes it.

Top module: `eaGen`

## Requirements
- R1: Mode 0 (register) returns the base value as an operand (resIsOperand=1). Mode 1 (immediate) returns the sign-extended constant as an operand. Neither mode issues a memory request.
- R2: Mode 2 (displacement) returns address base + sext(const). Mode 3 (register indirect) returns address base. Mode 4 (indexed) returns address base + index. All use resIsOperand=0 and issue no memory request.
- R3: Mode 5 (absolute) returns the sign-extended constant as the address.
- R4: Mode 6 (memory indirect) issues exactly one memory read at the base value. memReqValid and memReqAddr stay unchanged until memReqReady. busy is 1 from acceptance until the response arrives. The result address equals memRspData.
- R5: Mode 7 (post-increment) returns address base and raises resWbEn with resWbValue = base + d.
- R6: Mode 8 (pre-decrement) returns base - d both as the address and as resWbValue, with resWbEn=1. No other mode raises resWbEn.
- R7: Mode 9 (scaled) returns address sext(const) + base + index*d, where the multiply is a left shift. Sums wrap modulo 2^32.
- R8: Access size d is 1, 2 and 4 bytes for size codes 0, 1 and 2. Code 3 also means 4 bytes.
- R9: Mode codes 10 to 15 set resIllegal=1, resValue=0 and resWbEn=0, and issue no memory request.
- R10: reqReady is 1 only when the unit is idle and holds no result. The result fields and resValid stay stable until resReady. reqReady returns one cycle after the result is taken.
- R11: After reset, reqReady=1 and resValid, memReqValid and busy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle, request accepted this cycle |
| reqMode | input | 4 | Addressing mode code |
| reqBase | input | 32 | Base register value |
| reqIndex | input | 32 | Index register value |
| reqConst | input | 16 | Constant field, sign-extended inside |
| reqSize | input | 2 | Access size code |
| memReqValid | output | 1 | Pointer read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Pointer read address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data (pointer word) |
| resValid | output | 1 | Result present |
| resReady | input | 1 | Consumer takes result |
| resValue | output | 32 | Operand or final address |
| resIsOperand | output | 1 | 1: resValue is an operand, 0: an address |
| resWbEn | output | 1 | Base register write-back required |
| resWbValue | output | 32 | Base register write-back value |
| resIllegal | output | 1 | Mode code was unassigned |
| busy | output | 1 | Pointer read in progress |

## Verification
On every cycle the assertions check the handshake rules. A pending pointer read keeps its valid and address. A pending result keeps its valid and fields. busy and reqReady never overlap. A write-back is only flagged for the two update modes. The arithmetic of each mode can only be shown by the bench. So can the size decoding, the wrap-around cases, the silence of the memory port for non-indirect and illegal codes, and the pointer-to-address substitution. The bench sweeps every mode code against every size code and several operand patterns.

// File: rtl/eaGenPkg.sv
package eaGenPkg;

  typedef enum logic [3:0] {
    MODE_REG      = 4'd0,
    MODE_IMM      = 4'd1,
    MODE_DISP     = 4'd2,
    MODE_REG_IND  = 4'd3,
    MODE_INDEXED  = 4'd4,
    MODE_ABS      = 4'd5,
    MODE_MEM_IND  = 4'd6,
    MODE_POST_INC = 4'd7,
    MODE_PRE_DEC  = 4'd8,
    MODE_SCALED   = 4'd9
  } eaMode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PTR_REQ,
    ST_PTR_WAIT,
    ST_DONE
  } eaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture request and computed result
    logic loadRsp;   // overwrite result with pointer word
  } eaStrobe_t;

endpackage

// File: rtl/eaGenCtrl.sv
module eaGenCtrl
  import eaGenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [3:0] reqMode,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       resReady,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       resValid,
  output logic       busy,
  output eaStrobe_t  strobe
);

  eaState_e stateQ, stateD;
  logic     isIndirect;

  assign isIndirect = (reqMode == MODE_MEM_IND);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:     if (reqValid) stateD = isIndirect ? ST_PTR_REQ : ST_DONE;
      ST_PTR_REQ:  if (memReqReady) stateD = ST_PTR_WAIT;
      ST_PTR_WAIT: if (memRspValid) stateD = ST_DONE;
      ST_DONE:     if (resReady) stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady       = (stateQ == ST_IDLE);
  assign memReqValid    = (stateQ == ST_PTR_REQ);
  assign resValid       = (stateQ == ST_DONE);
  assign busy           = (stateQ == ST_PTR_REQ) || (stateQ == ST_PTR_WAIT);
  assign strobe.loadReq = reqReady && reqValid;
  assign strobe.loadRsp = (stateQ == ST_PTR_WAIT) && memRspValid;

  p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady && !resValid);

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid);

  p_ready_after_take_r10: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resReady |=> reqReady);

endmodule

// File: rtl/eaGenDatapath.sv
module eaGenDatapath
  import eaGenPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CONST_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  eaStrobe_t          strobe,
  input  logic [3:0]         reqMode,
  input  logic [ADDR_W-1:0]  reqBase,
  input  logic [ADDR_W-1:0]  reqIndex,
  input  logic [CONST_W-1:0] reqConst,
  input  logic [1:0]         reqSize,
  input  logic [ADDR_W-1:0]  memRspData,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [ADDR_W-1:0]  resValue,
  output logic               resIsOperand,
  output logic               resWbEn,
  output logic [ADDR_W-1:0]  resWbValue,
  output logic               resIllegal
);

  localparam int EXT_W = (ADDR_W > CONST_W) ? ADDR_W - CONST_W : 1;

  logic [ADDR_W-1:0] constExt, accessBytes, scaledIdx;
  logic [1:0]        shAmt;
  logic [ADDR_W-1:0] nValue, nWbValue;
  logic              nIsOp, nWbEn, nIllegal;

  generate
    if (CONST_W >= ADDR_W) begin : g_noExt
      assign constExt = reqConst[ADDR_W-1:0];
    end else begin : g_signExt
      assign constExt = {{EXT_W{reqConst[CONST_W-1]}}, reqConst};
    end
  endgenerate

  // size code 3 reuses the widest access
  assign shAmt       = (reqSize == 2'd3) ? 2'd2 : reqSize;
  assign accessBytes = ADDR_W'(1) << shAmt;
  assign scaledIdx   = reqIndex << shAmt;

  always_comb begin
    nValue   = '0;
    nWbValue = '0;
    nIsOp    = 1'b0;
    nWbEn    = 1'b0;
    nIllegal = 1'b0;
    case (reqMode)
      MODE_REG:      begin nValue = reqBase;  nIsOp = 1'b1; end
      MODE_IMM:      begin nValue = constExt; nIsOp = 1'b1; end
      MODE_DISP:     nValue = reqBase + constExt;
      MODE_REG_IND:  nValue = reqBase;
      MODE_INDEXED:  nValue = reqBase + reqIndex;
      MODE_ABS:      nValue = constExt;
      MODE_MEM_IND:  nValue = '0;            // filled by pointer word
      MODE_POST_INC: begin
        nValue   = reqBase;
        nWbEn    = 1'b1;
        nWbValue = reqBase + accessBytes;
      end
      MODE_PRE_DEC:  begin
        nValue   = reqBase - accessBytes;
        nWbEn    = 1'b1;
        nWbValue = reqBase - accessBytes;
      end
      MODE_SCALED:   nValue = constExt + reqBase + scaledIdx;
      default:       nIllegal = 1'b1;
    endcase
  end

  logic [3:0] modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ        <= '0;
      memReqAddr   <= '0;
      resValue     <= '0;
      resIsOperand <= 1'b0;
      resWbEn      <= 1'b0;
      resWbValue   <= '0;
      resIllegal   <= 1'b0;
    end else if (strobe.loadReq) begin
      modeQ        <= reqMode;
      memReqAddr   <= reqBase;
      resValue     <= nValue;
      resIsOperand <= nIsOp;
      resWbEn      <= nWbEn;
      resWbValue   <= nWbValue;
      resIllegal   <= nIllegal;
    end else if (strobe.loadRsp) begin
      resValue     <= memRspData;
    end
  end

  p_wb_modes_r6: assert property (@(posedge clk) disable iff (!rstN)
    resWbEn |-> (modeQ == MODE_POST_INC) || (modeQ == MODE_PRE_DEC));

  p_illegal_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    resIllegal |-> !resWbEn && !resIsOperand);

endmodule

// File: rtl/eaGen.sv
module eaGen
  import eaGenPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CONST_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [3:0]         reqMode,
  input  logic [ADDR_W-1:0]  reqBase,
  input  logic [ADDR_W-1:0]  reqIndex,
  input  logic [CONST_W-1:0] reqConst,
  input  logic [1:0]         reqSize,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [ADDR_W-1:0]  memReqAddr,
  input  logic               memRspValid,
  input  logic [ADDR_W-1:0]  memRspData,
  output logic               resValid,
  input  logic               resReady,
  output logic [ADDR_W-1:0]  resValue,
  output logic               resIsOperand,
  output logic               resWbEn,
  output logic [ADDR_W-1:0]  resWbValue,
  output logic               resIllegal,
  output logic               busy
);

  eaStrobe_t strobe;

  eaGenCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .resReady(resReady),
    .reqReady(reqReady), .memReqValid(memReqValid), .resValid(resValid),
    .busy(busy), .strobe(strobe)
  );

  eaGenDatapath #(.ADDR_W(ADDR_W), .CONST_W(CONST_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqMode(reqMode),
    .reqBase(reqBase), .reqIndex(reqIndex), .reqConst(reqConst),
    .reqSize(reqSize), .memRspData(memRspData), .memReqAddr(memReqAddr),
    .resValue(resValue), .resIsOperand(resIsOperand), .resWbEn(resWbEn),
    .resWbValue(resWbValue), .resIllegal(resIllegal)
  );

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  p_res_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> $stable(resValue) && $stable(resWbValue)
                              && $stable(resWbEn) && $stable(resIllegal));

  p_no_ptr_illegal_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !resIllegal && !resIsOperand);

endmodule

// File: tb/eaGen_tb.sv
module eaGen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady;
  logic [3:0]  reqMode = '0;
  logic [31:0] reqBase = '0, reqIndex = '0;
  logic [15:0] reqConst = '0;
  logic [1:0]  reqSize = '0;
  logic        memReqValid, memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        resValid, resReady = 1'b0;
  logic [31:0] resValue, resWbValue;
  logic        resIsOperand, resWbEn, resIllegal, busy;

  int nChecks = 0, nErr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  eaGen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqBase(reqBase), .reqIndex(reqIndex),
    .reqConst(reqConst), .reqSize(reqSize), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .resValid(resValid),
    .resReady(resReady), .resValue(resValue), .resIsOperand(resIsOperand),
    .resWbEn(resWbEn), .resWbValue(resWbValue), .resIllegal(resIllegal),
    .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runTxn(input logic [3:0] mode, input logic [1:0] size,
                        input logic [31:0] base, input logic [31:0] idx,
                        input logic [15:0] cst);
    logic [31:0] cExt, d, ptr, expVal, expWbV;
    logic        expOp, expWb, expIll, expMem;
    int          memSeen, sh;
    string       tag;
    sh   = (size == 2'd3) ? 2 : int'(size);
    d    = 32'd1 << sh;
    cExt = {{16{cst[15]}}, cst};
    ptr  = (base ^ 32'h5A5A_0F0F) + {30'd0, size};
    expVal = '0; expWbV = '0; expOp = 0; expWb = 0; expIll = 0; expMem = 0;
    case (mode)
      4'd0: begin expVal = base; expOp = 1; tag = "R1"; end
      4'd1: begin expVal = cExt; expOp = 1; tag = "R1"; end
      4'd2: begin expVal = base + cExt; tag = "R2"; end
      4'd3: begin expVal = base; tag = "R2"; end
      4'd4: begin expVal = base + idx; tag = "R2"; end
      4'd5: begin expVal = cExt; tag = "R3"; end
      4'd6: begin expVal = ptr; expMem = 1; tag = "R4"; end
      4'd7: begin expVal = base; expWb = 1; expWbV = base + d; tag = "R5 R8"; end
      4'd8: begin expVal = base - d; expWb = 1; expWbV = base - d; tag = "R6 R8"; end
      4'd9: begin expVal = cExt + base + (idx << sh); tag = "R7 R8"; end
      default: begin expIll = 1; tag = "R9"; end
    endcase

    @(negedge clk);
    chk("R10 ready when idle", {31'd0, reqReady}, 32'd1);
    reqMode = mode; reqSize = size; reqBase = base; reqIndex = idx;
    reqConst = cst; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reqBase = ~base; reqIndex = ~idx; reqConst = ~cst;  // must not matter now
    memSeen = 0;
    for (int c = 0; c < 40 && !resValid; c++) begin
      if (memReqValid) begin
        memSeen++;
        chk("R4 ptr addr", memReqAddr, base);
        chk("R4 busy", {31'd0, busy}, 32'd1);
        chk("R10 not ready while busy", {31'd0, reqReady}, 32'd0);
        for (int s = 0; s < int'(base[1:0]); s++) begin
          @(negedge clk);
          chk("R4 req held", {31'd0, memReqValid}, 32'd1);
          chk("R4 addr held", memReqAddr, base);
        end
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        chk("R4 single req", {31'd0, memReqValid}, 32'd0);
        chk("R4 busy wait", {31'd0, busy}, 32'd1);
        memRspValid = 1'b1; memRspData = ptr;
        @(negedge clk);
        memRspValid = 1'b0; memRspData = '0;
      end else begin
        @(negedge clk);
      end
    end
    chk({tag, " result valid"}, {31'd0, resValid}, 32'd1);
    chk({tag, " mem access"}, memSeen, {31'd0, expMem});
    chk({tag, " value"}, resValue, expVal);
    chk({tag, " isOperand"}, {31'd0, resIsOperand}, {31'd0, expOp});
    chk({tag, " wbEn"}, {31'd0, resWbEn}, {31'd0, expWb});
    if (expWb) chk({tag, " wbValue"}, resWbValue, expWbV);
    chk({tag, " illegal"}, {31'd0, resIllegal}, {31'd0, expIll});
    chk("R10 busy off", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R10 result held", resValue, expVal);
    chk("R10 valid held", {31'd0, resValid}, 32'd1);
    chk("R10 no ready held", {31'd0, reqReady}, 32'd0);
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    chk("R10 released", {31'd0, resValid}, 32'd0);
    chk("R10 ready again", {31'd0, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [3];
    logic [31:0] idxs  [3];
    logic [15:0] csts  [3];
    bases[0] = 32'h0000_1000; idxs[0] = 32'h0000_0003; csts[0] = 16'h0010;
    bases[1] = 32'h8000_0005; idxs[1] = 32'h0000_0040; csts[1] = 16'hFFF0;
    bases[2] = 32'h0000_0002; idxs[2] = 32'h7FFF_FFFF; csts[2] = 16'h8000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reqReady", {31'd0, reqReady}, 32'd1);
    chk("R11 resValid", {31'd0, resValid}, 32'd0);
    chk("R11 memReqValid", {31'd0, memReqValid}, 32'd0);
    chk("R11 busy", {31'd0, busy}, 32'd0);
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 16; m++)
        for (int s = 0; s < 4; s++)
          runTxn(4'(m), 2'(s), bases[p], idxs[p], csts[p]);
    // R6 wrap below zero, R7 wrap above top
    runTxn(4'd8, 2'd2, 32'h0000_0000, 32'd0, 16'd0);
    runTxn(4'd9, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h7FFF);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule